// File: doc/BRIEF.md
# LPC Host Interrupt Aggregator

This block collects the interrupt sources of an LPC host controller and steers them to the controller's interrupt outputs. Sources set bits in a 32-bit sticky host status register. A mask register selects which of those bits are active. A serial-interrupt enable bit can withdraw the serial-interrupt sources, which are status bits 0 to 15. The active set then goes down one of two routes, selected by a static mode input.

In routed mode, each active serial-interrupt source is steered by its own 2-bit route field to one of four serial-interrupt lines. These lines follow the register state without a latch. All remaining internal sources feed the aggregated path. In merged mode, every active source feeds the aggregated path and the four lines stay low.

The aggregated path drives one bit of an OPB-side input word. A sticky OPB status register collects the masked input bits, and the host-controller interrupt line is high while that register holds any set bit. A failed OPB-side transaction reported on a dedicated input sets the sync no-response error bit. Software reaches every register through a simple write/read port.

Top module: `lpcirq_agg_top`

## Requirements
- R1: After a synchronous reset, every register reads 0, the four serial-interrupt lines are low and the host-controller interrupt line is low.
- R2: Host status register (address 0). Each cycle it takes on its old value with the written-1 bits cleared, ORed with src_set_i, and with bit 20 set when bus_fail_i is high. When a source sets a bit in the same cycle that software clears it, the set wins.
- R3: The active set is the host status register ANDed with the mask register (address 1). A status bit whose mask bit is 0 changes no output.
- R4: When bit 0 of the control register (address 2) is 0, status bits 0 to 15 are removed from the active set before any routing.
- R5: In routed mode (route_mode_i = 1), serial line L is high while some active source s in 0..15 has route field bits [2s+1:2s] of the route register (address 3) equal to L. The line follows the register state in the same cycle.
- R6: In routed mode, bits 0 to 15 are excluded from the aggregated path, and active bits 16 to 31 still feed it.
- R7: In merged mode (route_mode_i = 0), all active bits feed the aggregated path and the four serial lines stay low.
- R8: Bit 0 of the OPB input word (address 4, read-only) is 1 exactly while the aggregated path has any active bit. All other bits of that word read 0, and writes to it have no effect.
- R9: OPB status (address 6) is sticky. On each clock edge it ORs in the OPB input word ANDed with the OPB mask (address 5). Writing 1s clears bits, and a bit that is being set at the same edge stays set.
- R10: hc_irq_o is high exactly while the OPB status register is nonzero.
- R11: The polarity register (address 7) reads back what was written and has no effect on any output.
- R12: reg_rdata_o shows the register at reg_addr_i one clock edge later. It reflects the state from before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_mode_i | input | 1 | Static mode: 1 routes serial sources to lines, 0 merges all sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| src_set_i | input | 32 | Per-bit set pulses into the host status register |
| bus_fail_i | input | 1 | Failed OPB-side transaction; sets status bit 20 |
| serirq_o | output | 4 | Routed serial-interrupt lines |
| hc_irq_o | output | 1 | Aggregated host-controller interrupt |

## Verification
On every cycle, the assertions check the following:
- the serial lines are quiet when the block is in merged mode, when the serial enable is off, or when nothing is active;
- status bits stay set unless they are cleared, and a failed transaction always leaves the error bit set;
- the OPB status register is sticky;
- every rise of the host-controller line has a masked OPB input behind it.

The bench's reference model and its scenarios cover the rest:
- the steering of each source to the line its field selects;
- the exclusion of serial bits from the latched path in routed mode;
- merged-mode aggregation;
- set-over-clear priority;
- the lack of effect of the polarity register;
- readback timing.

// File: rtl/lpcirq_pkg.sv
package lpcirq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_HC_STAT  = 3'd0,
    RA_HC_MASK  = 3'd1,
    RA_CTRL     = 3'd2,
    RA_ROUTE    = 3'd3,
    RA_OPB_IN   = 3'd4,
    RA_OPB_MASK = 3'd5,
    RA_OPB_STAT = 3'd6,
    RA_POLARITY = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/lpcirq_regs.sv
module lpcirq_regs
  import lpcirq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NSER       = 16,
  parameter int RT_W       = 2,
  parameter int NORESP_BIT = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [DATA_W-1:0]      src_set,
  input  logic                   bus_fail,
  input  logic [DATA_W-1:0]      opb_in,
  input  logic [DATA_W-1:0]      opb_stat,
  output logic [DATA_W-1:0]      hc_stat,
  output logic [DATA_W-1:0]      hc_mask,
  output logic                   ser_en,
  output logic [NSER*RT_W-1:0]   route,
  output logic [DATA_W-1:0]      opb_mask,
  output logic [DATA_W-1:0]      opb_clr,
  output logic [DATA_W-1:0]      rdata
);
  localparam int ROUTE_W = NSER * RT_W;

  logic [DATA_W-1:0] polarity;
  logic [DATA_W-1:0] stat_clr;
  logic [DATA_W-1:0] noresp_vec;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] route_ext;

  assign stat_clr   = (we && addr == RA_HC_STAT)  ? wdata : '0;
  assign opb_clr    = (we && addr == RA_OPB_STAT) ? wdata : '0;
  assign noresp_vec = DATA_W'(bus_fail) << NORESP_BIT;

  always_comb begin
    route_ext = '0;
    route_ext[ROUTE_W-1:0] = route;
  end

  always_comb begin
    case (addr)
      RA_HC_STAT:  rd_mux = hc_stat;
      RA_HC_MASK:  rd_mux = hc_mask;
      RA_CTRL:     rd_mux = DATA_W'(ser_en);
      RA_ROUTE:    rd_mux = route_ext;
      RA_OPB_IN:   rd_mux = opb_in;
      RA_OPB_MASK: rd_mux = opb_mask;
      RA_OPB_STAT: rd_mux = opb_stat;
      default:     rd_mux = polarity;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_stat  <= '0;
      hc_mask  <= '0;
      ser_en   <= 1'b0;
      route    <= '0;
      opb_mask <= '0;
      polarity <= '0;
      rdata    <= '0;
    end else begin
      hc_stat <= (hc_stat & ~stat_clr) | src_set | noresp_vec;
      rdata   <= rd_mux;
      if (we) begin
        case (addr)
          RA_HC_MASK:  hc_mask  <= wdata;
          RA_CTRL:     ser_en   <= wdata[0];
          RA_ROUTE:    route    <= wdata[ROUTE_W-1:0];
          RA_OPB_MASK: opb_mask <= wdata;
          RA_POLARITY: polarity <= wdata;
          default:     ;
        endcase
      end
    end
  end

  AST_NORESP_SETS: assert property (@(posedge clk) disable iff (rst)
    bus_fail |=> hc_stat[NORESP_BIT]); // R2

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hc_stat) & ~$past(stat_clr)) & ~hc_stat) == '0); // R2
endmodule

// File: rtl/lpcirq_router.sv
module lpcirq_router #(
  parameter int DATA_W = 32,
  parameter int NSER   = 16,
  parameter int NLINE  = 4,
  parameter int RT_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 route_mode,
  input  logic [DATA_W-1:0]    hc_stat,
  input  logic [DATA_W-1:0]    hc_mask,
  input  logic                 ser_en,
  input  logic [NSER*RT_W-1:0] route,
  output logic [NLINE-1:0]     ser_lines,
  output logic                 remain_any
);
  localparam logic [DATA_W-1:0] SER_BITS = DATA_W'((64'd1 << NSER) - 64'd1);

  logic [DATA_W-1:0] active;
  logic [DATA_W-1:0] gated;
  logic [DATA_W-1:0] remain;

  assign active = hc_stat & hc_mask;
  assign gated  = ser_en ? active : (active & ~SER_BITS);
  assign remain = route_mode ? (gated & ~SER_BITS) : gated;
  assign remain_any = |remain;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [NSER-1:0] hit;
    always_comb begin
      for (int s = 0; s < NSER; s++) begin
        hit[s] = gated[s] && (route[s*RT_W +: RT_W] == RT_W'(l));
      end
    end
    assign ser_lines[l] = route_mode && (|hit);
  end

  AST_MERGED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !route_mode |-> ser_lines == '0); // R7

  AST_SER_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ser_en |-> ser_lines == '0); // R4
endmodule

// File: rtl/lpcirq_opb_latch.sv
module lpcirq_opb_latch #(
  parameter int DATA_W  = 32,
  parameter int LPC_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              remain_any,
  input  logic [DATA_W-1:0] opb_mask,
  input  logic [DATA_W-1:0] opb_clr,
  output logic [DATA_W-1:0] opb_in,
  output logic [DATA_W-1:0] opb_stat,
  output logic              irq
);
  assign opb_in = DATA_W'(remain_any) << LPC_BIT;
  assign irq    = |opb_stat;

  always_ff @(posedge clk) begin
    if (rst) opb_stat <= '0;
    else     opb_stat <= (opb_stat & ~opb_clr) | (opb_in & opb_mask);
  end

  AST_OPB_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(opb_stat) & ~$past(opb_clr)) & ~opb_stat) == '0); // R9

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((opb_in & opb_mask) != '0)); // R10
endmodule

// File: rtl/lpcirq_agg_top.sv
module lpcirq_agg_top
  import lpcirq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NSER       = 16,
  parameter int NLINE      = 4,
  parameter int NORESP_BIT = 20,
  parameter int LPC_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              route_mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [DATA_W-1:0] src_set_i,
  input  logic              bus_fail_i,
  output logic [NLINE-1:0]  serirq_o,
  output logic              hc_irq_o
);
  localparam int RT_W = (NLINE > 1) ? $clog2(NLINE) : 1;

  logic [DATA_W-1:0]    hc_stat, hc_mask, opb_mask, opb_clr, opb_in, opb_stat;
  logic                 ser_en, remain_any;
  logic [NSER*RT_W-1:0] route;

  lpcirq_regs #(
    .DATA_W(DATA_W), .NSER(NSER), .RT_W(RT_W), .NORESP_BIT(NORESP_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .src_set(src_set_i), .bus_fail(bus_fail_i), .opb_in(opb_in),
    .opb_stat(opb_stat), .hc_stat(hc_stat), .hc_mask(hc_mask), .ser_en(ser_en),
    .route(route), .opb_mask(opb_mask), .opb_clr(opb_clr), .rdata(reg_rdata_o)
  );

  lpcirq_router #(
    .DATA_W(DATA_W), .NSER(NSER), .NLINE(NLINE), .RT_W(RT_W)
  ) u_router (
    .clk(clk), .rst(rst), .route_mode(route_mode_i), .hc_stat(hc_stat),
    .hc_mask(hc_mask), .ser_en(ser_en), .route(route),
    .ser_lines(serirq_o), .remain_any(remain_any)
  );

  lpcirq_opb_latch #(
    .DATA_W(DATA_W), .LPC_BIT(LPC_BIT)
  ) u_opb (
    .clk(clk), .rst(rst), .remain_any(remain_any), .opb_mask(opb_mask),
    .opb_clr(opb_clr), .opb_in(opb_in), .opb_stat(opb_stat), .irq(hc_irq_o)
  );

  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (hc_stat & hc_mask) == '0 |-> (serirq_o == '0 && opb_in == '0)); // R3
endmodule

// File: tb/tb_lpcirq_agg_top.sv
`timescale 1ns/1ps
module tb_lpcirq_agg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src = '0;
  logic        fail = 1'b0;
  logic [3:0]  ser;
  logic        irq;

  always #2.5 clk = ~clk;

  lpcirq_agg_top dut (
    .clk(clk), .rst(rst), .route_mode_i(mode), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_set_i(src),
    .bus_fail_i(fail), .serirq_o(ser), .hc_irq_o(irq)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_stat, m_mask, m_route, m_opbm, m_opbs, m_pol, m_rdata;
  bit m_en;

  function automatic logic [31:0] m_active();
    logic [31:0] a = m_stat & m_mask;
    if (!m_en) a = a & 32'hFFFF_0000;
    return a;
  endfunction

  function automatic logic [3:0] m_ser();
    logic [3:0] o = '0;
    logic [31:0] a = m_active();
    if (mode) begin
      for (int s = 0; s < 16; s++) begin
        if (a[s]) o[(m_route >> (2 * s)) & 3] = 1'b1;
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] m_opbin();
    logic [31:0] a = m_active();
    if (mode) a = a & 32'hFFFF_0000;
    return (a != 0) ? 32'd1 : 32'd0;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_stat;
      3'd1: return m_mask;
      3'd2: return {31'd0, m_en};
      3'd3: return m_route;
      3'd4: return m_opbin();
      3'd5: return m_opbm;
      3'd6: return m_opbs;
      default: return m_pol;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] nstat, nopbs, clr_s, clr_o;
    cycles++;
    started = 1;
    if (rst) begin
      m_stat = 0; m_mask = 0; m_route = 0; m_opbm = 0; m_opbs = 0;
      m_pol = 0; m_rdata = 0; m_en = 0;
    end else begin
      m_rdata = m_read(addr);
      clr_s = (we && addr == 3'd0) ? wdata : 32'd0;
      clr_o = (we && addr == 3'd6) ? wdata : 32'd0;
      nstat = (m_stat & ~clr_s) | src;
      if (fail) nstat[20] = 1'b1;
      nopbs = (m_opbs & ~clr_o) | (m_opbin() & m_opbm);
      if (we) begin
        case (addr)
          3'd1: m_mask = wdata;
          3'd2: m_en = wdata[0];
          3'd3: m_route = wdata;
          3'd5: m_opbm = wdata;
          3'd7: m_pol = wdata;
          default: ;
        endcase
      end
      m_stat = nstat;
      m_opbs = nopbs;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5", "serial lines", {28'd0, ser}, {28'd0, m_ser()});
      chk("R10", "hc irq", {31'd0, irq}, {31'd0, (m_opbs != 0)});
      chk("R12", "read data", rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a;
    @(negedge clk);
    chk(tag, "readback", rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); src = v;
    @(negedge clk); src = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    // R1: reset state
    chk("R1", "lines after reset", {28'd0, ser}, 32'd0);
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 8; a++) rd("R1", 3'(a), 32'd0);

    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'h0000_080C);   // s1 -> line3, s5 -> line2, others line0
    wr(3'd5, 32'd1);
    rd("R12", 3'd3, 32'h0000_080C);

    pulse(32'h0000_0002);
    chk("R5", "source1 to line3", {28'd0, ser}, 32'h8);
    idle(2);
    chk("R6", "serial bit kept off latch", {31'd0, irq}, 32'd0);
    rd("R8", 3'd4, 32'd0);
    pulse(32'h0000_0020);
    chk("R5", "source5 adds line2", {28'd0, ser}, 32'hC);

    wr(3'd2, 32'd0);
    chk("R4", "disable silences lines", {28'd0, ser}, 32'd0);
    wr(3'd2, 32'd1);

    pulse(32'h0100_0000);
    idle(2);
    chk("R6", "internal bit latches", {31'd0, irq}, 32'd1);
    rd("R8", 3'd4, 32'd1);
    wr(3'd4, 32'hFFFF_FFFF);
    rd("R8", 3'd4, 32'd1);

    wr(3'd0, 32'h0100_0000);
    idle(2);
    chk("R9", "opb status sticky after source clear", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'd1);
    idle(1);
    chk("R9", "opb status cleared", {31'd0, irq}, 32'd0);
    rd("R9", 3'd6, 32'd0);

    wr(3'd1, 32'hFFFF_FFDD);   // mask off sources 1 and 5
    chk("R3", "masked serial idle", {28'd0, ser}, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);

    @(negedge clk); fail = 1;
    @(negedge clk); fail = 0;
    rd("R2", 3'd0, 32'h0010_0022);
    idle(2);
    chk("R2", "noresp raises irq", {31'd0, irq}, 32'd1);

    // set wins over clear in the same cycle
    @(negedge clk); we = 1; addr = 3'd0; wdata = 32'h0000_0008; src = 32'h0000_0008;
    @(negedge clk); we = 0; src = 0;
    rd("R2", 3'd0, 32'h0010_002A);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R2", 3'd0, 32'd0);

    wr(3'd7, 32'hFFFF_FFFF);
    rd("R11", 3'd7, 32'hFFFF_FFFF);
    pulse(32'h0000_0002);
    chk("R11", "polarity no effect", {28'd0, ser}, 32'h8);

    // merged mode
    @(negedge clk); rst = 1; mode = 0;
    idle(2);
    @(negedge clk); rst = 0;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'd1);
    wr(3'd5, 32'd1);
    pulse(32'h0000_0002);
    chk("R7", "merged lines quiet", {28'd0, ser}, 32'd0);
    idle(2);
    chk("R7", "serial source merged onto irq", {31'd0, irq}, 32'd1);
    rd("R7", 3'd4, 32'd1);
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule